// File: doc/BRIEF.md
# Saturating Signed Add/Subtract Unit

This unit adds or subtracts two signed two's-complement operands of a parameterized width (32 bits by default). Each operation is either saturating or flag-only. In saturating mode an overflowing result is replaced by the extreme value that matches the sign of the first operand. In flag-only mode the wrapped result is written unchanged.

In both modes every overflow sets a sticky saturation flag. The arithmetic never lowers this flag. Only a dedicated clear strobe lowers it, so software or a sequencer can run a series of operations and then ask once whether any of them overflowed.

The result and the flag are registered. A valid strobe marks each operation, and result-valid follows it one cycle later.

Top module: `sat_addsub_unit`

## Requirements
- R1: With `opSub`=0 and no overflow, `result` equals the wrapped sum `opA + opB`.
- R2: With `opSub`=1 and no overflow, `result` equals the wrapped difference `opA - opB`, where `opA` is the minuend.
- R3: An addition overflows when `opA` and `opB` have equal sign bits and the sign bit of the wrapped sum differs from that of `opA`. Such an overflow sets `stickyFlag`.
- R4: A subtraction overflows when `opA` and `opB` have different sign bits and the sign bit of the wrapped difference differs from that of `opA`. Such an overflow sets `stickyFlag`.
- R5: With `satMode`=1, an overflowing operation (add or subtract) writes the largest positive value (0x7FFFFFFF at 32 bits) when `opA` is non-negative. It writes the most negative value (exactly 0x80000000 at 32 bits) when `opA` is negative.
- R6: With `satMode`=0, an overflowing operation writes the wrapped result and still sets `stickyFlag`.
- R7: Once set, `stickyFlag` stays set across any number of operations while `clrFlag` is low.
- R8: A cycle with `clrFlag`=1 clears `stickyFlag` unless an overflowing operation is accepted in the same cycle, in which case the flag is set (overflow wins).
- R9: `resultValid` is high exactly one cycle after each cycle with `inValid`=1. `result` holds its value when `inValid` is low.
- R10: Synchronous active-high `rst` drives `result`, `resultValid` and `stickyFlag` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Accept an operation this cycle |
| opSub | input | 1 | 0 = add, 1 = subtract (opA - opB) |
| satMode | input | 1 | 1 = saturate on overflow, 0 = flag-only |
| clrFlag | input | 1 | Clear the sticky flag |
| opA | input | DATA_W | First operand / minuend, signed |
| opB | input | DATA_W | Second operand / subtrahend, signed |
| result | output | DATA_W | Registered result |
| resultValid | output | 1 | Result written by the previous cycle's operation |
| stickyFlag | output | 1 | Sticky overflow flag |

## Verification
The bench builds two copies of the unit. The first has `DATA_W`=6, which makes an exhaustive sweep possible: every operand pair with both operations and both modes, with clear strobes mixed in. That sweep reaches every overflow boundary and every clamp direction, and the bench checks each outcome against arithmetic done at full precision. The second copy has the default width of 32. It takes directed operations at the literal extremes 0x7FFFFFFF and 0x80000000, and it also covers the clear/overflow collision, flag persistence, the hold of the result during idle cycles, and reset.

// File: rtl/satu_pkg.sv
package satu_pkg;
  typedef struct packed {
    logic load;
    logic doSub;
    logic doSat;
    logic clrFlag;
  } satuStrobes_t;
endpackage

// File: rtl/satu_ctrl.sv
module satu_ctrl
  import satu_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         opSub,
  input  logic         satMode,
  input  logic         clrFlag,
  output satuStrobes_t strb,
  output logic         resultValid
);
  always_comb begin
    strb.load    = inValid;
    strb.doSub   = opSub;
    strb.doSat   = satMode;
    strb.clrFlag = clrFlag;
  end

  always_ff @(posedge clk) begin
    if (rst) resultValid <= 1'b0;
    else     resultValid <= inValid;
  end

  // R9: result-valid follows the strobe by exactly one cycle
  p_valid_lat_r9: assert property (@(posedge clk) disable iff (rst)
    inValid |=> resultValid);
  p_valid_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !resultValid);
  // R10: reset clears result-valid
  p_reset_valid_r10: assert property (@(posedge clk)
    rst |=> !resultValid);
endmodule

// File: rtl/satu_datapath.sv
module satu_datapath
  import satu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  satuStrobes_t      strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              stickyFlag
);
  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {MSB{1'b1}}};
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {MSB{1'b0}}};

  logic [DATA_W-1:0] opBEff, rawRes, clampVal, nextRes;
  logic signA, signB, signR, ovf;

  always_comb begin
    opBEff   = strb.doSub ? ~opB : opB;
    rawRes   = opA + opBEff + {{MSB{1'b0}}, strb.doSub};
    signA    = opA[MSB];
    signB    = opB[MSB];
    signR    = rawRes[MSB];
    if (strb.doSub) ovf = (signA != signB) && (signR != signA);
    else            ovf = (signA == signB) && (signR != signA);
    clampVal = signA ? MIN_NEG : MAX_POS;
    nextRes  = (strb.doSat && ovf) ? clampVal : rawRes;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result     <= '0;
      stickyFlag <= 1'b0;
    end else begin
      if (strb.load) result <= nextRes;
      if (strb.load && ovf)  stickyFlag <= 1'b1;
      else if (strb.clrFlag) stickyFlag <= 1'b0;
    end
  end

  // R3/R4: the flag only rises after an accepted operation
  p_flag_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(stickyFlag) |-> $past(strb.load));
  // R7: without clear or operation the flag is unchanged
  p_flag_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!strb.load && !strb.clrFlag) |=> $stable(stickyFlag));
  // R8: a clear with no operation lowers the flag
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (strb.clrFlag && !strb.load) |=> !stickyFlag);
  // R8: an overflow always leaves the flag set
  p_ovf_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (strb.load && ovf) |=> stickyFlag);
  // R5: a saturated result is one of the two extremes
  p_sat_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (strb.load && strb.doSat && ovf) |=> (result == MAX_POS || result == MIN_NEG));
  // R9: result holds while idle
  p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> $stable(result));
endmodule

// File: rtl/sat_addsub_unit.sv
module sat_addsub_unit
  import satu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              opSub,
  input  logic              satMode,
  input  logic              clrFlag,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              resultValid,
  output logic              stickyFlag
);
  satuStrobes_t strb;

  satu_ctrl ctrl_i (
    .clk(clk), .rst(rst), .inValid(inValid), .opSub(opSub),
    .satMode(satMode), .clrFlag(clrFlag), .strb(strb),
    .resultValid(resultValid)
  );

  satu_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .opA(opA), .opB(opB),
    .result(result), .stickyFlag(stickyFlag)
  );
endmodule

// File: tb/sat_addsub_unit_tb_top.sv
module sat_addsub_unit_tb_top;
  localparam int SW = 6;
  localparam int WW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int nChecks = 0;
  int nErr = 0;

  // small instance
  logic sValid = 0, sSub = 0, sSat = 0, sClr = 0;
  logic [SW-1:0] sA = '0, sB = '0, sRes;
  logic sRv, sFlag;
  // wide instance
  logic wValid = 0, wSub = 0, wSat = 0, wClr = 0;
  logic [WW-1:0] wA = '0, wB = '0, wRes;
  logic wRv, wFlag;

  sat_addsub_unit #(.DATA_W(WW)) dut_i (
    .clk(clk), .rst(rst), .inValid(wValid), .opSub(wSub), .satMode(wSat),
    .clrFlag(wClr), .opA(wA), .opB(wB), .result(wRes),
    .resultValid(wRv), .stickyFlag(wFlag)
  );

  sat_addsub_unit #(.DATA_W(SW)) dutSmall_i (
    .clk(clk), .rst(rst), .inValid(sValid), .opSub(sSub), .satMode(sSat),
    .clrFlag(sClr), .opA(sA), .opB(sB), .result(sRes),
    .resultValid(sRv), .stickyFlag(sFlag)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model at full precision
  task automatic model(input int w, input logic [63:0] a, input logic [63:0] b,
                       input logic sub, input logic sat,
                       output logic [63:0] res, output logic ovf);
    longint sa, sb, tr, mx, mn;
    logic [63:0] mask;
    mask = (64'd1 << w) - 64'd1;
    sa = longint'(a << (64 - w)) >>> (64 - w);
    sb = longint'(b << (64 - w)) >>> (64 - w);
    tr = sub ? sa - sb : sa + sb;
    mx = (longint'(1) << (w - 1)) - 1;
    mn = -(longint'(1) << (w - 1));
    ovf = (tr > mx) || (tr < mn);
    if (ovf && sat) res = (sa < 0) ? (64'(mn) & mask) : 64'(mx);
    else            res = 64'(tr) & mask;
  endtask

  task automatic wOp(input logic [31:0] a, input logic [31:0] b,
                     input logic sub, input logic sat, input logic clr);
    @(negedge clk);
    wA = a; wB = b; wSub = sub; wSat = sat; wClr = clr; wValid = 1;
    @(negedge clk);
    wValid = 0; wClr = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nErr++; nChecks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin : main
    logic [63:0] er;
    logic eo, expFlag;
    string rtag, ftag;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 result", wRes, 0);
    chk("R10 resultValid", wRv, 0);
    chk("R10 stickyFlag", wFlag, 0);
    chk("R10 small result", sRes, 0);
    rst = 0;

    // exhaustive sweep on the small instance
    expFlag = 0;
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < (1 << SW); a++) begin
        for (int b = 0; b < (1 << SW); b++) begin
          sA = SW'(a); sB = SW'(b); sSub = m[0]; sSat = m[1];
          sClr = ((a + b) % 5 == 0); sValid = 1;
          model(SW, 64'(a), 64'(b), m[0], m[1], er, eo);
          if (eo) expFlag = 1; else if (sClr) expFlag = 0;
          rtag = eo ? (m[1] ? "R5" : "R6") : (m[0] ? "R2" : "R1");
          ftag = eo ? (m[0] ? "R4" : "R3") : (sClr ? "R8" : "R7");
          @(negedge clk);
          chk(rtag, 64'(sRes), er);
          chk(ftag, 64'(sFlag), 64'(expFlag));
          chk("R9 small valid", 64'(sRv), 1);
        end
      end
    end
    sValid = 0; sClr = 0;

    // directed, 32-bit extremes
    wOp(32'h7FFFFFFF, 32'h00000001, 0, 1, 0);
    chk("R5 add pos clamp", wRes, 64'h7FFFFFFF);
    chk("R3 flag set", wFlag, 1);
    chk("R9 valid", wRv, 1);
    @(negedge clk);
    chk("R9 valid low when idle", wRv, 0);
    chk("R9 result held", wRes, 64'h7FFFFFFF);
    wOp(32'h00000005, 32'h00000003, 0, 1, 0);
    chk("R1 plain add", wRes, 64'h8);
    chk("R7 flag persists", wFlag, 1);
    wOp(32'h0, 32'h0, 0, 0, 0);
    wValid = 0; wClr = 1; @(negedge clk); wClr = 0;
    chk("R8 clear alone", wFlag, 0);
    wOp(32'h80000000, 32'hFFFFFFFF, 0, 1, 0);
    chk("R5 add neg clamp", wRes, 64'h80000000);
    wOp(32'h80000000, 32'h00000001, 1, 1, 1);
    chk("R5 sub neg clamp exact", wRes, 64'h80000000);
    chk("R8 overflow wins over clear", wFlag, 1);
    wOp(32'h7FFFFFFF, 32'hFFFFFFFF, 1, 1, 0);
    chk("R5 sub pos clamp", wRes, 64'h7FFFFFFF);
    chk("R4 flag", wFlag, 1);
    wOp(32'h80000000, 32'h80000000, 1, 1, 1);
    chk("R2 equal extremes", wRes, 0);
    chk("R8 clear with clean op", wFlag, 0);
    wOp(32'h7FFFFFFF, 32'h00000001, 0, 0, 0);
    chk("R6 wrapped add", wRes, 64'h80000000);
    chk("R6 flag still set", wFlag, 1);
    wOp(32'h80000000, 32'h00000001, 1, 0, 0);
    chk("R6 wrapped sub", wRes, 64'h7FFFFFFF);
    wOp(32'h12345678, 32'h02345678, 1, 0, 0);
    chk("R2 plain sub", wRes, 64'h10000000);
    @(negedge clk);
    rst = 1; @(negedge clk); rst = 0;
    chk("R10 reset result", wRes, 0);
    chk("R10 reset flag", wFlag, 0);

    $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule